// File: doc/BRIEF.md
# Redirected Interrupt Delivery Engine

This block turns the levels on a set of interrupt pins into delivery requests for a processor-side interrupt fabric. Each pin owns a programmable entry that holds a vector, a destination, a destination mode, a delivery mode, a trigger mode (edge or level) and a mask bit. The block keeps a request bit for each pin. For level pins it also keeps a remote-in-service bit and a repeat counter. It issues at most one delivery request at a time. When several pins are waiting, the lowest-numbered pin goes first.

End-of-interrupt (EOI) notices arrive with a vector. They release level pins that are waiting on that vector, and they re-deliver a level pin whose line is still asserted. If a pin's line stays asserted across many EOIs in a row, the block stops re-delivering it at once and lets a delayed retry timer pick it up later. This slows an interrupt storm down without losing the interrupt.

The delivery output is a valid/ready stream. Once `out_valid` rises, it and the whole payload hold steady until a cycle in which `out_ready` is high. In that same cycle the fabric reports, on `out_accepted`, whether any processor took the request. A new request can be loaded in the cycle the previous one completes.

Top module: `irq_dispatch`

## Requirements
- R1: After reset, every entry is masked, no request or remote bit is set, `out_valid` is low and any pending delayed retry is cancelled. A retry that was scheduled before reset never causes a delivery.
- R2: An edge pin delivers once each time its line goes from low to high. Holding the line high causes no further delivery. Driving the line low clears the request bit.
- R3: A level pin is delivered when its line rises while its remote bit is clear. A line that rises while the remote bit is set is not delivered. A completed level delivery with `out_accepted` high sets that pin's remote bit.
- R4: A masked entry is never delivered, but its request bit is still recorded. Unmasking an edge entry whose line is already high does not deliver it; a fresh rise is needed.
- R5: An EOI whose vector equals a level entry's vector clears that entry's remote bit. If the entry is unmasked and its line is still high, the repeat counter increments and the pin is delivered again. Otherwise the repeat counter returns to zero.
- R6: An EOI that arrives with `eoi_directed` high changes no remote bit and causes no re-delivery.
- R7: The EOI that brings a pin's repeat counter up to STORM_LIMIT causes no immediate delivery. It zeroes the counter and schedules a retry `retry_delay`+1 cycles later. The retry then serves every unmasked level pin whose line is high and whose remote bit is clear.
- R8: Writing an entry clears its remote bit. If the written entry is level-triggered and its line is high, a delivery is attempted at once.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and every payload field hold their values. Only one request is outstanding at a time.
- R10: When several pins are pending together, the lowest-numbered pin is issued first.
- R11: A level delivery completed with `out_accepted` low leaves the remote bit clear, so the next rise of that line is delivered again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_level | input | NPINS | Interrupt line levels, one bit per pin |
| cfg_we | input | 1 | Write strobe for one entry |
| cfg_idx | input | IDX_W | Index of the entry to write (values of NPINS or more are ignored) |
| cfg_vector | input | 8 | Vector for the written entry |
| cfg_dest | input | 8 | Destination for the written entry |
| cfg_dest_logical | input | 1 | Destination mode for the written entry (1 = logical) |
| cfg_dlv_mode | input | 3 | Delivery mode for the written entry |
| cfg_level | input | 1 | Trigger mode for the written entry (1 = level, 0 = edge) |
| cfg_mask | input | 1 | Mask bit for the written entry (1 = masked) |
| eoi_valid | input | 1 | One-cycle EOI notice |
| eoi_vector | input | 8 | Vector carried by the EOI |
| eoi_directed | input | 1 | When high, EOI notices are ignored by this block |
| retry_delay | input | DLY_W | Cycles to wait before the delayed retry fires |
| out_valid | output | 1 | Delivery request pending |
| out_ready | input | 1 | Fabric completes the request in this cycle |
| out_accepted | input | 1 | With out_ready: at least one processor took the request |
| out_pin | output | IDX_W | Pin the request belongs to |
| out_vector | output | 8 | Vector of the request |
| out_dest | output | 8 | Destination of the request |
| out_dest_logical | output | 1 | Destination mode of the request |
| out_dlv_mode | output | 3 | Delivery mode of the request |
| out_level | output | 1 | Trigger mode of the request (1 = level) |

## Verification
The bench drives single-pin edge rises, held lines and rapid low-high toggles. These separate the once-per-rise rule for edge pins from the remote-bit hold-off for level pins. A chain of EOIs on a held level line makes the repeat counter climb. This shows the immediate re-deliveries, the one suppressed delivery at the limit, and a retry that arrives neither early nor never. A line that drops between EOIs checks that the counter is cleared. Directed-mode EOIs, unmasking a line that is already high, and entry rewrites each test a path where a delivery must or must not appear. Two lines rising together under back-pressure expose both the issue order and the payload hold. A reset taken while a retry is scheduled shows the retry is cancelled.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int VEC_W   = 8;
  localparam int DEST_W  = 8;
  localparam int DMODE_W = 3;

  typedef struct packed {
    logic               mask;
    logic               level;
    logic [DMODE_W-1:0] dmode;
    logic               dest_logical;
    logic [DEST_W-1:0]  dest;
    logic [VEC_W-1:0]   vector;
  } irq_entry_t;

  localparam irq_entry_t ENTRY_RST = '{mask: 1'b1, level: 1'b0, dmode: '0,
                                       dest_logical: 1'b0, dest: '0, vector: '0};
endpackage

// File: rtl/irqd_pin.sv
// Per-pin state: entry, request bit, remote bit, pending-service bit, repeat counter.
module irqd_pin
  import irqd_pkg::*;
#(
  parameter int STORM_LIMIT = 10000,
  parameter int CNT_W       = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic             wr_en,
  input  irq_entry_t       wr_entry,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  input  logic             eoi_directed,
  input  logic             retry_fire,
  input  logic             grant,
  input  logic             set_remote,
  output irq_entry_t       entry_o,
  output logic             remote_o,
  output logic             pend_o,
  output logic             storm_o
);
  irq_entry_t       ent_q, ent_n;
  logic             irr_q, remote_q, remote_n, pend_q, pend_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             rise, eoi_hit, serve_ok, storm, redeliver, set_pend, keep;

  always_comb begin
    ent_n     = wr_en ? wr_entry : ent_q;
    rise      = pin_in & ~irr_q;
    eoi_hit   = eoi_valid & ~eoi_directed & ent_q.level & (ent_q.vector == eoi_vector);
    serve_ok  = eoi_hit & ~ent_q.mask & irr_q;
    storm     = serve_ok && (cnt_q == CNT_W'(STORM_LIMIT - 1));
    redeliver = serve_ok & ~storm;

    cnt_n = cnt_q;
    if (eoi_hit) begin
      if (serve_ok) cnt_n = storm ? '0 : cnt_q + 1'b1;
      else          cnt_n = '0;
    end

    remote_n = remote_q;
    if (wr_en || eoi_hit) remote_n = 1'b0;
    if (set_remote)       remote_n = 1'b1;

    set_pend = rise
             | (wr_en & wr_entry.level & irr_q)
             | redeliver
             | (retry_fire & ent_q.level & irr_q & ~remote_q);
    keep     = ~ent_n.mask & (~ent_n.level | (pin_in & ~remote_n));
    pend_n   = ((pend_q & ~grant) | set_pend) & keep;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_q    <= ENTRY_RST;
      irr_q    <= 1'b0;
      remote_q <= 1'b0;
      pend_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      ent_q    <= ent_n;
      irr_q    <= pin_in;
      remote_q <= remote_n;
      pend_q   <= pend_n;
      cnt_q    <= cnt_n;
    end
  end

  assign entry_o  = ent_q;
  assign remote_o = remote_q;
  assign pend_o   = pend_q;
  assign storm_o  = storm;
endmodule

// File: rtl/irqd_pick.sv
// Lowest-index-first selector.
module irqd_pick #(
  parameter int N     = 24,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irqd_retry.sv
// One-shot delay timer for the storm retry. Arming while armed is ignored.
module irqd_retry #(
  parameter int DLY_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [DLY_W-1:0] delay,
  output logic             fire
);
  logic             armed_q;
  logic [DLY_W-1:0] cnt_q;

  assign fire = armed_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (arm && (!armed_q || fire)) begin
      armed_q <= 1'b1;
      cnt_q   <= delay;
    end else if (fire) begin
      armed_q <= 1'b0;
    end else if (armed_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irqd_pkg::*;
#(
  parameter int  NPINS       = 24,
  parameter int  STORM_LIMIT = 10000,
  parameter int  DLY_W       = 24,
  localparam int IDX_W       = $clog2(NPINS),
  localparam int CNT_W       = $clog2(STORM_LIMIT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   pin_level,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [VEC_W-1:0]   cfg_vector,
  input  logic [DEST_W-1:0]  cfg_dest,
  input  logic               cfg_dest_logical,
  input  logic [DMODE_W-1:0] cfg_dlv_mode,
  input  logic               cfg_level,
  input  logic               cfg_mask,
  input  logic               eoi_valid,
  input  logic [VEC_W-1:0]   eoi_vector,
  input  logic               eoi_directed,
  input  logic [DLY_W-1:0]   retry_delay,
  output logic               out_valid,
  input  logic               out_ready,
  input  logic               out_accepted,
  output logic [IDX_W-1:0]   out_pin,
  output logic [VEC_W-1:0]   out_vector,
  output logic [DEST_W-1:0]  out_dest,
  output logic               out_dest_logical,
  output logic [DMODE_W-1:0] out_dlv_mode,
  output logic               out_level
);
  irq_entry_t       wr_entry;
  irq_entry_t       ent_w [NPINS];
  irq_entry_t       sel_ent;
  logic [NPINS-1:0] pend_w, remote_w, storm_w, grant_w, mask_w, inflight, avail;
  logic             pick_any, load, hs, retry_fire;
  logic [IDX_W-1:0] pick_idx;

  always_comb begin
    wr_entry.mask         = cfg_mask;
    wr_entry.level        = cfg_level;
    wr_entry.dmode        = cfg_dlv_mode;
    wr_entry.dest_logical = cfg_dest_logical;
    wr_entry.dest         = cfg_dest;
    wr_entry.vector       = cfg_vector;
  end

  assign hs = out_valid & out_ready;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic wr_hit, set_rem;
    assign wr_hit  = cfg_we && (cfg_idx == IDX_W'(g));
    assign set_rem = hs && out_accepted && out_level && (out_pin == IDX_W'(g));

    irqd_pin #(.STORM_LIMIT(STORM_LIMIT), .CNT_W(CNT_W)) pin_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_in      (pin_level[g]),
      .wr_en       (wr_hit),
      .wr_entry    (wr_entry),
      .eoi_valid   (eoi_valid),
      .eoi_vector  (eoi_vector),
      .eoi_directed(eoi_directed),
      .retry_fire  (retry_fire),
      .grant       (grant_w[g]),
      .set_remote  (set_rem),
      .entry_o     (ent_w[g]),
      .remote_o    (remote_w[g]),
      .pend_o      (pend_w[g]),
      .storm_o     (storm_w[g])
    );
    assign mask_w[g] = ent_w[g].mask;
  end

  // The pin in flight cannot be picked again until its handshake has settled.
  assign inflight = out_valid ? (NPINS'(1) << out_pin) : '0;
  assign avail    = pend_w & ~inflight;

  irqd_pick #(.N(NPINS), .IDX_W(IDX_W)) pick_i (
    .req(avail),
    .any(pick_any),
    .idx(pick_idx)
  );

  assign load    = pick_any & (~out_valid | out_ready);
  assign grant_w = load ? (NPINS'(1) << pick_idx) : '0;
  assign sel_ent = ent_w[pick_idx];

  irqd_retry #(.DLY_W(DLY_W)) retry_i (
    .clk  (clk),
    .rst_n(rst_n),
    .arm  (|storm_w),
    .delay(retry_delay),
    .fire (retry_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid        <= 1'b0;
      out_pin          <= '0;
      out_vector       <= '0;
      out_dest         <= '0;
      out_dest_logical <= 1'b0;
      out_dlv_mode     <= '0;
      out_level        <= 1'b0;
    end else if (load) begin
      out_valid        <= 1'b1;
      out_pin          <= pick_idx;
      out_vector       <= sel_ent.vector;
      out_dest         <= sel_ent.dest;
      out_dest_logical <= sel_ent.dest_logical;
      out_dlv_mode     <= sel_ent.dmode;
      out_level        <= sel_ent.level;
    end else if (out_ready) begin
      out_valid        <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
  parameter int NPINS = 24,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_accepted,
  input logic [IDX_W-1:0] out_pin,
  input logic [7:0]       out_vector,
  input logic [7:0]       out_dest,
  input logic             out_dest_logical,
  input logic [2:0]       out_dlv_mode,
  input logic             out_level,
  input logic             eoi_valid,
  input logic             eoi_directed,
  input logic             cfg_we,
  input logic [NPINS-1:0] mask_vec,
  input logic [NPINS-1:0] remote_vec
);
  logic [NPINS-1:0] prev_mask, prev_remote;
  logic             prev_hold, new_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_mask   <= '1;
      prev_remote <= '0;
      prev_hold   <= 1'b0;
    end else begin
      prev_mask   <= mask_vec;
      prev_remote <= remote_vec;
      prev_hold   <= out_valid & ~out_ready;
    end
  end

  assign new_req = out_valid & ~prev_hold;

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pin) && $stable(out_vector)
      && $stable(out_dest) && $stable(out_dest_logical) && $stable(out_dlv_mode) && $stable(out_level));

  // R4
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_req |-> !prev_mask[out_pin]);

  // R3
  remote_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_req && out_level |-> !prev_remote[out_pin]);

  // R3
  remote_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_accepted && out_level |=> remote_vec[$past(out_pin)]);

  // R11
  no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_accepted && !remote_vec[out_pin] |=> !remote_vec[$past(out_pin)]);

  // R6
  directed_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid && eoi_directed && !cfg_we && !(out_valid && out_ready) |=> $stable(remote_vec));
endmodule

bind irq_dispatch irq_dispatch_chk #(.NPINS(NPINS), .IDX_W(IDX_W)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .out_valid       (out_valid),
  .out_ready       (out_ready),
  .out_accepted    (out_accepted),
  .out_pin         (out_pin),
  .out_vector      (out_vector),
  .out_dest        (out_dest),
  .out_dest_logical(out_dest_logical),
  .out_dlv_mode    (out_dlv_mode),
  .out_level       (out_level),
  .eoi_valid       (eoi_valid),
  .eoi_directed    (eoi_directed),
  .cfg_we          (cfg_we),
  .mask_vec        (mask_w),
  .remote_vec      (remote_w)
);

// File: tb/irq_dispatch_tb_top.sv
module irq_dispatch_tb_top;
  localparam int NPINS = 8;
  localparam int LIMIT = 4;
  localparam int DLY_W = 16;
  localparam int DELAY = 50;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NPINS-1:0] pin_level = '0;
  logic             cfg_we = 1'b0;
  logic [2:0]       cfg_idx = '0;
  logic [7:0]       cfg_vector = '0, cfg_dest = '0;
  logic             cfg_dest_logical = 1'b0, cfg_level = 1'b0, cfg_mask = 1'b1;
  logic [2:0]       cfg_dlv_mode = '0;
  logic             eoi_valid = 1'b0, eoi_directed = 1'b0;
  logic [7:0]       eoi_vector = '0;
  logic [DLY_W-1:0] retry_delay = DLY_W'(DELAY);
  logic             out_valid, out_ready = 1'b1, out_accepted = 1'b1;
  logic [2:0]       out_pin, out_dlv_mode;
  logic [7:0]       out_vector, out_dest;
  logic             out_dest_logical, out_level;

  always #5 clk = ~clk;

  irq_dispatch #(.NPINS(NPINS), .STORM_LIMIT(LIMIT), .DLY_W(DLY_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_vector(cfg_vector), .cfg_dest(cfg_dest),
    .cfg_dest_logical(cfg_dest_logical), .cfg_dlv_mode(cfg_dlv_mode),
    .cfg_level(cfg_level), .cfg_mask(cfg_mask),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_directed(eoi_directed),
    .retry_delay(retry_delay),
    .out_valid(out_valid), .out_ready(out_ready), .out_accepted(out_accepted),
    .out_pin(out_pin), .out_vector(out_vector), .out_dest(out_dest),
    .out_dest_logical(out_dest_logical), .out_dlv_mode(out_dlv_mode), .out_level(out_level)
  );

  typedef struct { int pin; int vec; int lvl; string req; } exp_t;
  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 0;

  task automatic check(bit ok, string req, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  endtask

  // Monitor: pops one expected item per completed handshake.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "unexpected delivery", int'(out_pin), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(int'(out_pin) == e.pin, {e.req, " pin"}, int'(out_pin), e.pin);
        check(int'(out_vector) == e.vec, {e.req, " vector"}, int'(out_vector), e.vec);
        check(int'(out_level) == e.lvl, {e.req, " trigger"}, int'(out_level), e.lvl);
      end
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      check(0, "watchdog", wd, 20000);
      finish_run();
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_dlv(int pin, int vec, int lvl, string req);
    exp_t e;
    e.pin = pin; e.vec = vec; e.lvl = lvl; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic drain(int n, string req);
    step(n);
    check(exp_q.size() == 0, {req, " pending deliveries"}, exp_q.size(), 0);
  endtask

  task automatic cfg(int idx, int vec, bit lvl, bit msk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_vector = 8'(vec); cfg_level = lvl; cfg_mask = msk;
    cfg_dest = 8'(idx + 1); cfg_dlv_mode = 3'd0; cfg_dest_logical = 1'b0;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic eoi(int vec, bit directed);
    eoi_valid = 1'b1; eoi_vector = 8'(vec); eoi_directed = directed;
    step(1);
    eoi_valid = 1'b0; eoi_directed = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
  endtask

  initial begin
    step(1);
    do_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
    step(1);
    // R1: all entries masked after reset
    pin_level[0] = 1'b1;
    drain(8, "R1 masked after reset");
    pin_level[0] = 1'b0;
    step(2);

    cfg(0, 'h30, 0, 0);
    cfg(1, 'h41, 1, 0);
    cfg(2, 'h52, 0, 1);
    cfg(3, 'h63, 1, 0);
    cfg(4, 'h74, 0, 0);

    // R2: edge pin delivers once per rise
    expect_dlv(0, 'h30, 0, "R2 edge rise");
    pin_level[0] = 1'b1;
    drain(6, "R2 first rise");
    drain(10, "R2 held high");
    pin_level[0] = 1'b0;
    step(2);
    expect_dlv(0, 'h30, 0, "R2 second rise");
    pin_level[0] = 1'b1;
    drain(6, "R2 second rise");
    pin_level[0] = 1'b0;

    // R4: masked entry records but never delivers
    pin_level[2] = 1'b1;
    drain(8, "R4 masked rise");
    cfg(2, 'h52, 0, 0);
    drain(8, "R4 unmask with line high");
    pin_level[2] = 1'b0;
    step(2);
    expect_dlv(2, 'h52, 0, "R4 rise after unmask");
    pin_level[2] = 1'b1;
    drain(6, "R4 rise after unmask");
    pin_level[2] = 1'b0;

    // R3: level pin, remote bit holds off a new rise
    expect_dlv(1, 'h41, 1, "R3 level rise");
    pin_level[1] = 1'b1;
    drain(6, "R3 level rise");
    pin_level[1] = 1'b0;
    step(1);
    pin_level[1] = 1'b1;
    drain(8, "R3 rise while remote set");

    // R5: EOI re-delivery, R7: storm at the limit
    for (int k = 0; k < LIMIT - 1; k++) begin
      expect_dlv(1, 'h41, 1, "R5 eoi redelivery");
      eoi('h41, 0);
      drain(6, "R5 eoi redelivery");
    end
    eoi('h41, 0);
    drain(10, "R7 no immediate delivery at limit");
    expect_dlv(1, 'h41, 1, "R7 delayed retry");
    step(30);
    check(exp_q.size() == 1, "R7 retry not early", exp_q.size(), 1);
    drain(40, "R7 delayed retry");

    // R6: directed EOI ignored
    eoi('h41, 1);
    drain(10, "R6 directed eoi");
    expect_dlv(1, 'h41, 1, "R6 normal eoi after directed");
    eoi('h41, 0);
    drain(6, "R6 normal eoi after directed");

    // R5: EOI with line low clears remote and counter
    pin_level[1] = 1'b0;
    step(2);
    eoi('h41, 0);
    drain(10, "R5 eoi with line low");
    expect_dlv(1, 'h41, 1, "R5 rise after release");
    pin_level[1] = 1'b1;
    drain(6, "R5 rise after release");
    for (int k = 0; k < LIMIT - 1; k++) begin
      expect_dlv(1, 'h41, 1, "R5 counter restarted from zero");
      eoi('h41, 0);
      drain(6, "R5 counter restarted from zero");
    end
    eoi('h41, 0);
    drain(10, "R7 second storm");
    expect_dlv(1, 'h41, 1, "R7 second retry");
    drain(70, "R7 second retry");

    // R11: level delivery not accepted leaves remote clear
    out_accepted = 1'b0;
    expect_dlv(3, 'h63, 1, "R11 unaccepted level");
    pin_level[3] = 1'b1;
    drain(6, "R11 unaccepted level");
    pin_level[3] = 1'b0;
    step(1);
    expect_dlv(3, 'h63, 1, "R11 re-rise after unaccepted");
    pin_level[3] = 1'b1;
    drain(6, "R11 re-rise after unaccepted");
    out_accepted = 1'b1;

    // R8: entry write with level and line high delivers; write clears remote
    expect_dlv(3, 'h63, 1, "R8 write with line high");
    cfg(3, 'h63, 1, 0);
    drain(6, "R8 write with line high");
    expect_dlv(3, 'h63, 1, "R8 write clears remote");
    cfg(3, 'h63, 1, 0);
    drain(6, "R8 write clears remote");

    // R9 and R10: back-pressure and lowest pin first
    out_ready = 1'b0;
    pin_level[4] = 1'b1;
    pin_level[0] = 1'b1;
    step(3);
    @(negedge clk);
    check(out_valid == 1'b1, "R9 valid under back-pressure", int'(out_valid), 1);
    check(out_pin == 3'd0, "R10 lowest pin first", int'(out_pin), 0);
    step(3);
    @(negedge clk);
    check(out_valid == 1'b1 && out_pin == 3'd0, "R9 hold pin", int'(out_pin), 0);
    check(out_vector == 8'h30, "R9 hold vector", int'(out_vector), 'h30);
    step(1);
    expect_dlv(0, 'h30, 0, "R10 first");
    expect_dlv(4, 'h74, 0, "R10 second");
    out_ready = 1'b1;
    drain(8, "R10 order");

    // R1: reset cancels a scheduled retry
    for (int k = 0; k < LIMIT - 1; k++) begin
      expect_dlv(1, 'h41, 1, "R1 setup redelivery");
      eoi('h41, 0);
      drain(6, "R1 setup redelivery");
    end
    eoi('h41, 0);
    step(5);
    do_reset();
    out_accepted = 1'b0;
    expect_dlv(1, 'h41, 1, "R1 write after reset");
    cfg(1, 'h41, 1, 0);
    drain(100, "R1 retry cancelled by reset");

    finish_run();
  end
endmodule